// File: doc/BRIEF.md
# UART Hardware Handshake Controller

This block runs the two-wire hardware handshake of a serial port. On the transmit side, it watches the active-low clear-to-send input through a synchronizer. When the far end withdraws permission, the block stops the local transmitter. The stop never cuts a character: a character that is already leaving finishes its stop bit before the transmitter is held. The transmitter is released once the input returns low.

On the receive side, the block drives the active-low request-to-send output from the receive FIFO fill level. It uses a window around the receive trigger level. The window half-width is chosen by a 2-bit code. The request is withdrawn only when the level climbs to the top of the window. It is granted again only after the FIFO drains to the bottom of the window. Reception itself is not blocked while the request is withdrawn; the FIFO keeps filling until it is full.

Both deassertion events can raise sticky status flags. Each flag is gated by a common enable and by its own enable. Both flags clear on a status read. A flag that is set in the same cycle as the read survives the read.

Top module: `uart_hs_flow`

## Requirements
- R1: After reset, `tx_allow` is 1, `tx_halted` is 0, `rx_trig_hit` is 0, both status flags are 0 and `irq` is 0. `rts_n_out` is 1 while `sw_rts_on` is 0.
- R2: With `auto_cts_en`=1 and `tx_busy`=0, a rise of `cts_n_in` drives `tx_allow` to 0 and `tx_halted` to 1. Both change on the third rising clock edge after the input change; two edges are synchronizer stages and one is the gate register.
- R3: If `tx_busy`=1 when the synchronized stop request arrives, `tx_allow` goes to 0 but `tx_halted` stays 0. `tx_halted` becomes 1 only on the edge that samples `tx_stop_done`=1.
- R4: While stopped, `cts_n_in` returning to 0 sets `tx_allow` back to 1 three edges later.
- R5: With `auto_cts_en`=0, `cts_n_in` has no effect: `tx_allow` stays 1, `tx_halted` stays 0 and the clear-to-send flag is not set.
- R6: With `auto_rts_en`=1 and `sw_rts_on`=1, `rts_n_out` goes to 1 one edge after `rx_level` is at or above the upper limit. The upper limit is min(`rx_trig`+H, FIFO_DEPTH). H is 0, 4, 6 or 8 for `hyst_sel` = 0, 1, 2 or 3.
- R7: Once `rts_n_out` is 1, it returns to 0 one edge after `rx_level` is at or below the lower limit, max(`rx_trig`−H, 0), and also below the upper limit.
- R8: With `sw_rts_on`=0, `rts_n_out` is 1 in every mode. With `auto_rts_en`=0, `rts_n_out` follows the inverse of `sw_rts_on` in the same cycle, whatever the FIFO level.
- R9: `rx_trig_hit` is 1 one edge after `rx_level` ≥ `rx_trig`, and 0 one edge after it drops below.
- R10: `rts_stat` and `cts_stat` set on an automatic deassertion only if both `irq_master_en` and their own enable are 1. The clear-to-send flag also needs `auto_cts_en`=1. `irq` is the OR of the two flags.
- R11: `stat_rd` clears both flags on the next edge. A flag whose set event falls in the same cycle as `stat_rd` ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_n_in | input | 1 | Clear-to-send from the far end, active low, asynchronous |
| tx_busy | input | 1 | Transmitter is shifting a character |
| tx_stop_done | input | 1 | One-cycle strobe at the end of a stop bit |
| tx_allow | output | 1 | Transmitter may start a character |
| tx_halted | output | 1 | Transmitter held at a character boundary |
| rx_level | input | LVL_W | Receive FIFO occupancy |
| rx_trig | input | LVL_W | Receive trigger level |
| hyst_sel | input | 2 | Window half-width code |
| sw_rts_on | input | 1 | Software request-to-send on; arms the automatic mode |
| rts_n_out | output | 1 | Request-to-send to the far end, active low |
| rx_trig_hit | output | 1 | FIFO level at or above trigger |
| auto_cts_en | input | 1 | Automatic transmit gating enable |
| auto_rts_en | input | 1 | Automatic request-to-send enable |
| irq_master_en | input | 1 | Common enable for both handshake flags |
| cts_irq_en | input | 1 | Clear-to-send flag enable |
| rts_irq_en | input | 1 | Request-to-send flag enable |
| stat_rd | input | 1 | Status read strobe, clears flags |
| cts_stat | output | 1 | Clear-to-send deassertion flag |
| rts_stat | output | 1 | Request-to-send deassertion flag |
| irq | output | 1 | Interrupt, OR of the flags |

## Verification
Two things can meet in one clock: a status read and a new deassertion event. If the clear in that cycle won, the event would be lost. The bench first leaves the request-to-send flag set. It then times `stat_rd` so that it is high on exactly the edge where the synchronized clear-to-send rise lands. On that edge it expects the clear-to-send flag to read 1, the older request-to-send flag to read 0, and `irq` to stay 1. A second read, with no event in its cycle, must then clear the surviving flag.

// File: rtl/hsflow_pkg.sv
package hsflow_pkg;

  typedef enum logic [1:0] {
    TXG_RUN   = 2'd0,
    TXG_DRAIN = 2'd1,
    TXG_HALT  = 2'd2
  } txg_state_e;

  localparam int HOFF_W = 4;

  // half-width of the request-to-send window for each select code
  function automatic logic [HOFF_W-1:0] hyst_offset(input logic [1:0] sel);
    logic [HOFF_W-1:0] off;
    case (sel)
      2'd0:    off = 4'd0;
      2'd1:    off = 4'd4;
      2'd2:    off = 4'd6;
      default: off = 4'd8;
    endcase
    return off;
  endfunction

endpackage

// File: rtl/hsflow_cts_sync.sv
module hsflow_cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_n_in,
  output logic cts_high,
  output logic cts_rise
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;
  logic              last_q;
  logic              last_d;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        assign sh_d[g] = cts_n_in;
      end else begin : g_next
        assign sh_d[g] = sh_q[g-1];
      end
    end
  endgenerate

  always_comb last_d = sh_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      last_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      last_q <= last_d;
    end
  end

  assign cts_high = sh_q[STAGES-1];
  assign cts_rise = sh_q[STAGES-1] & ~last_q;

  // R2: a stop request is reported as a single-cycle pulse
  a_r2_rise_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cts_rise |=> !cts_rise);

endmodule

// File: rtl/hsflow_tx_gate.sv
module hsflow_tx_gate
  import hsflow_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic auto_cts_en,
  input  logic cts_high,
  input  logic tx_busy,
  input  logic tx_stop_done,
  output logic tx_allow,
  output logic tx_halted
);
  txg_state_e state_q;
  txg_state_e state_d;
  logic       stop_req;

  assign stop_req = auto_cts_en & cts_high;

  always_comb begin
    state_d = state_q;
    case (state_q)
      TXG_RUN: begin
        if (stop_req) state_d = tx_busy ? TXG_DRAIN : TXG_HALT;
      end
      TXG_DRAIN: begin
        if (!stop_req)        state_d = TXG_RUN;
        else if (tx_stop_done) state_d = TXG_HALT;
      end
      TXG_HALT: begin
        if (!stop_req) state_d = TXG_RUN;
      end
      default: state_d = TXG_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= TXG_RUN;
    else        state_q <= state_d;
  end

  assign tx_allow  = (state_q == TXG_RUN);
  assign tx_halted = (state_q == TXG_HALT);

  // R3: the hold only begins at a character boundary
  a_r3_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_halted) |-> ($past(tx_stop_done) || !$past(tx_busy)));

  // R4: transmission resumes only once the stop request is gone
  a_r4_resume_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_allow) |-> $past(!cts_high || !auto_cts_en));

  // R5: with automatic gating off the transmitter is always free
  a_r5_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_cts_en |=> tx_allow);

endmodule

// File: rtl/hsflow_rts_ctl.sv
module hsflow_rts_ctl
  import hsflow_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_rts_en,
  input  logic             sw_rts_on,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_trig,
  input  logic [1:0]       hyst_sel,
  output logic             rts_n_out,
  output logic             rx_trig_hit,
  output logic             rts_off_evt
);
  localparam int            EXT_W   = LVL_W + 1;
  localparam logic [EXT_W-1:0] DEPTH_V = EXT_W'(FIFO_DEPTH);

  logic [EXT_W-1:0] off_ext;
  logic [EXT_W-1:0] trig_ext;
  logic [EXT_W-1:0] lvl_ext;
  logic [EXT_W-1:0] sum;
  logic [EXT_W-1:0] upper;
  logic [EXT_W-1:0] lower;
  logic             active;
  logic             off_q;
  logic             off_d;
  logic             hit_q;
  logic             hit_d;

  always_comb begin
    off_ext  = {{(EXT_W-HOFF_W){1'b0}}, hyst_offset(hyst_sel)};
    trig_ext = {1'b0, rx_trig};
    lvl_ext  = {1'b0, rx_level};
    sum      = trig_ext + off_ext;
    upper    = (sum > DEPTH_V) ? DEPTH_V : sum;
    lower    = (trig_ext > off_ext) ? (trig_ext - off_ext) : '0;
  end

  assign active = auto_rts_en & sw_rts_on;

  always_comb begin
    off_d = off_q;
    if (!active)                                        off_d = 1'b0;
    else if (!off_q && (lvl_ext >= upper))              off_d = 1'b1;
    else if (off_q && (lvl_ext <= lower) && (lvl_ext < upper)) off_d = 1'b0;
    hit_d = (rx_level >= rx_trig);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= 1'b0;
      hit_q <= 1'b0;
    end else begin
      off_q <= off_d;
      hit_q <= hit_d;
    end
  end

  assign rts_n_out   = ~sw_rts_on | (auto_rts_en & off_q);
  assign rx_trig_hit = hit_q;
  assign rts_off_evt = off_d & ~off_q;

  // R6: the request is withdrawn only at or past the upper window limit
  a_r6_off_at_upper: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(off_q) |-> $past(lvl_ext >= upper));

  // R7: the request comes back only at the lower limit, or when the mode is left
  a_r7_on_at_lower: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(off_q) |-> $past(!active || (lvl_ext <= lower)));

  // R8: software off always wins
  a_r8_sw_off: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_rts_on |-> rts_n_out);

  // R9: the trigger indication follows the FIFO level
  a_r9_trig_follow: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_trig_hit) |-> $past(rx_level >= rx_trig));

endmodule

// File: rtl/hsflow_stat.sv
module hsflow_stat #(
  parameter int NFLAG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_evt,
  input  logic             rd,
  output logic [NFLAG-1:0] stat
);
  logic [NFLAG-1:0] flag_q;
  logic [NFLAG-1:0] flag_d;

  genvar g;
  generate
    for (g = 0; g < NFLAG; g++) begin : g_flag
      always_comb begin
        if (set_evt[g])  flag_d[g] = 1'b1;
        else if (rd)     flag_d[g] = 1'b0;
        else             flag_d[g] = flag_q[g];
      end

      // R11: an event in the read cycle is not lost
      a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt[g] |=> stat[g]);

      // R11: a read with no event clears the flag
      a_r11_rd_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !set_evt[g]) |=> !stat[g]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign stat = flag_q;

endmodule

// File: rtl/uart_hs_flow.sv
module uart_hs_flow #(
  parameter int FIFO_DEPTH  = 64,
  parameter int SYNC_STAGES = 2,
  parameter int LVL_W       = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cts_n_in,
  input  logic             tx_busy,
  input  logic             tx_stop_done,
  output logic             tx_allow,
  output logic             tx_halted,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_trig,
  input  logic [1:0]       hyst_sel,
  input  logic             sw_rts_on,
  output logic             rts_n_out,
  output logic             rx_trig_hit,
  input  logic             auto_cts_en,
  input  logic             auto_rts_en,
  input  logic             irq_master_en,
  input  logic             cts_irq_en,
  input  logic             rts_irq_en,
  input  logic             stat_rd,
  output logic             cts_stat,
  output logic             rts_stat,
  output logic             irq
);
  localparam int FLAG_CTS = 0;
  localparam int FLAG_RTS = 1;
  localparam int NFLAG    = 2;

  logic             cts_high;
  logic             cts_rise;
  logic             rts_off_evt;
  logic [NFLAG-1:0] set_evt;
  logic [NFLAG-1:0] stat;

  hsflow_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .cts_n_in (cts_n_in),
    .cts_high (cts_high),
    .cts_rise (cts_rise)
  );

  hsflow_tx_gate u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .auto_cts_en  (auto_cts_en),
    .cts_high     (cts_high),
    .tx_busy      (tx_busy),
    .tx_stop_done (tx_stop_done),
    .tx_allow     (tx_allow),
    .tx_halted    (tx_halted)
  );

  hsflow_rts_ctl #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_rts (
    .clk         (clk),
    .rst_n       (rst_n),
    .auto_rts_en (auto_rts_en),
    .sw_rts_on   (sw_rts_on),
    .rx_level    (rx_level),
    .rx_trig     (rx_trig),
    .hyst_sel    (hyst_sel),
    .rts_n_out   (rts_n_out),
    .rx_trig_hit (rx_trig_hit),
    .rts_off_evt (rts_off_evt)
  );

  always_comb begin
    set_evt           = '0;
    set_evt[FLAG_CTS] = cts_rise & auto_cts_en & irq_master_en & cts_irq_en;
    set_evt[FLAG_RTS] = rts_off_evt & irq_master_en & rts_irq_en;
  end

  hsflow_stat #(.NFLAG(NFLAG)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (set_evt),
    .rd      (stat_rd),
    .stat    (stat)
  );

  assign cts_stat = stat[FLAG_CTS];
  assign rts_stat = stat[FLAG_RTS];
  assign irq      = |stat;

  // R10: with the common enable off no flag can newly set
  a_r10_master_gate_rts: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_master_en && !rts_stat) |=> !rts_stat);

  a_r10_master_gate_cts: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_master_en && !cts_stat) |=> !cts_stat);

  // R5: automatic gating off means no clear-to-send flag
  a_r5_no_cts_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_cts_en && !cts_stat) |=> !cts_stat);

endmodule

// File: tb/uart_hs_flow_test.sv
`timescale 1ns/1ps
module uart_hs_flow_test;
  localparam int DEPTH = 64;
  localparam int LW    = $clog2(DEPTH + 1);

  localparam int O_ALLOW = 0;
  localparam int O_HALT  = 1;
  localparam int O_RTS   = 2;
  localparam int O_TRIG  = 3;
  localparam int O_CSTAT = 4;
  localparam int O_RSTAT = 5;
  localparam int O_IRQ   = 6;

  typedef struct {
    int    cyc;
    int    idx;
    bit    val;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic cts_n_in, tx_busy, tx_stop_done, sw_rts_on;
  logic auto_cts_en, auto_rts_en, irq_master_en, cts_irq_en, rts_irq_en, stat_rd;
  logic [LW-1:0] rx_level, rx_trig;
  logic [1:0] hyst_sel;
  logic tx_allow, tx_halted, rts_n_out, rx_trig_hit, cts_stat, rts_stat, irq;

  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  exp_t sb[$];
  logic [6:0] obs;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_hs_flow #(.FIFO_DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .cts_n_in(cts_n_in), .tx_busy(tx_busy),
    .tx_stop_done(tx_stop_done), .tx_allow(tx_allow), .tx_halted(tx_halted),
    .rx_level(rx_level), .rx_trig(rx_trig), .hyst_sel(hyst_sel),
    .sw_rts_on(sw_rts_on), .rts_n_out(rts_n_out), .rx_trig_hit(rx_trig_hit),
    .auto_cts_en(auto_cts_en), .auto_rts_en(auto_rts_en),
    .irq_master_en(irq_master_en), .cts_irq_en(cts_irq_en),
    .rts_irq_en(rts_irq_en), .stat_rd(stat_rd), .cts_stat(cts_stat),
    .rts_stat(rts_stat), .irq(irq)
  );

  assign obs = {irq, rts_stat, cts_stat, rx_trig_hit, rts_n_out, tx_halted, tx_allow};

  function automatic string oname(input int i);
    case (i)
      O_ALLOW: return "tx_allow";
      O_HALT:  return "tx_halted";
      O_RTS:   return "rts_n_out";
      O_TRIG:  return "rx_trig_hit";
      O_CSTAT: return "cts_stat";
      O_RSTAT: return "rts_stat";
      default: return "irq";
    endcase
  endfunction

  // driver side: expected value of one output, d cycles from now
  task automatic expect_out(input int d, input int idx, input bit v, input string req);
    exp_t e;
    e.cyc = cyc + d;
    e.idx = idx;
    e.val = v;
    e.req = req;
    sb.push_back(e);
  endtask

  task automatic t(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: settles after each falling edge, then compares due items
  initial begin
    forever begin
      @(negedge clk);
      #1;
      for (int i = sb.size() - 1; i >= 0; i--) begin
        if (sb[i].cyc <= cyc) begin
          n_chk++;
          if (sb[i].cyc < cyc || obs[sb[i].idx] !== sb[i].val) begin
            n_fail++;
            $display("FAIL %s: %s actual %0b expected %0b at cycle %0d",
                     sb[i].req, oname(sb[i].idx), obs[sb[i].idx], sb[i].val, cyc);
          end
          sb.delete(i);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cts_n_in = 1'b0; tx_busy = 1'b0; tx_stop_done = 1'b0;
    sw_rts_on = 1'b0; auto_cts_en = 1'b1; auto_rts_en = 1'b1;
    irq_master_en = 1'b1; cts_irq_en = 1'b1; rts_irq_en = 1'b1; stat_rd = 1'b0;
    rx_level = '0; rx_trig = LW'(16); hyst_sel = 2'd1;
    t(3);
    rst_n = 1'b1;
    // R1 reset state
    expect_out(0, O_ALLOW, 1, "R1"); expect_out(0, O_HALT, 0, "R1");
    expect_out(0, O_RTS, 1, "R1");   expect_out(0, O_TRIG, 0, "R1");
    expect_out(0, O_CSTAT, 0, "R1"); expect_out(0, O_RSTAT, 0, "R1");
    expect_out(0, O_IRQ, 0, "R1");
    t(1);
    // R8 automatic mode not armed by software
    rx_level = LW'(20);
    expect_out(1, O_TRIG, 1, "R9"); expect_out(1, O_RTS, 1, "R8");
    expect_out(2, O_RSTAT, 0, "R8");
    t(3);
    rx_level = '0; sw_rts_on = 1'b1;
    expect_out(0, O_RTS, 0, "R8"); expect_out(1, O_TRIG, 0, "R9");
    t(2);
    // R6 window +-4 around 16: off at 20
    rx_level = LW'(19); expect_out(1, O_RTS, 0, "R6"); t(2);
    rx_level = LW'(20);
    expect_out(1, O_RTS, 1, "R6"); expect_out(1, O_RSTAT, 1, "R10");
    expect_out(1, O_IRQ, 1, "R10");
    t(2);
    stat_rd = 1'b1;
    expect_out(1, O_RSTAT, 0, "R11"); expect_out(1, O_IRQ, 0, "R11");
    t(1); stat_rd = 1'b0; t(1);
    // R7 on again at 12
    rx_level = LW'(13); expect_out(1, O_RTS, 1, "R7"); t(2);
    rx_level = LW'(12); expect_out(1, O_RTS, 0, "R7"); t(2);
    // R6/R7 code 3 near the top: upper clamps to 64, lower 52
    hyst_sel = 2'd3; rx_trig = LW'(60);
    rx_level = LW'(63); expect_out(1, O_RTS, 0, "R6"); t(2);
    rx_level = LW'(64); expect_out(1, O_RTS, 1, "R6"); t(2);
    rx_level = LW'(53); expect_out(1, O_RTS, 1, "R7"); t(2);
    rx_level = LW'(52); expect_out(1, O_RTS, 0, "R7"); t(2);
    // code 0: no window, on only below the trigger
    hyst_sel = 2'd0; rx_trig = LW'(16); rx_level = LW'(16);
    expect_out(1, O_RTS, 1, "R6"); t(3);
    expect_out(0, O_RTS, 1, "R7");
    rx_level = LW'(15); expect_out(1, O_RTS, 0, "R7"); t(2);
    // code 2 near the bottom: lower clamps to 0, upper 9
    hyst_sel = 2'd2; rx_trig = LW'(3); rx_level = LW'(9);
    expect_out(1, O_RTS, 1, "R6"); t(2);
    rx_level = LW'(1); expect_out(1, O_RTS, 1, "R7"); t(2);
    rx_level = LW'(0); expect_out(1, O_RTS, 0, "R7"); t(2);
    stat_rd = 1'b1; t(1); stat_rd = 1'b0;
    // R10 common enable off
    irq_master_en = 1'b0; rx_level = LW'(9);
    expect_out(1, O_RTS, 1, "R6"); expect_out(1, O_RSTAT, 0, "R10");
    t(2);
    rx_level = '0; irq_master_en = 1'b1; t(2);
    // R8 automatic mode off
    auto_rts_en = 1'b0; rx_level = LW'(64);
    expect_out(0, O_RTS, 0, "R8"); expect_out(1, O_RTS, 0, "R8"); t(2);
    sw_rts_on = 1'b0; expect_out(0, O_RTS, 1, "R8"); t(1);
    sw_rts_on = 1'b1; auto_rts_en = 1'b1; rx_level = '0;
    expect_out(0, O_RTS, 0, "R8"); t(2);
    // R2 stop request between characters
    cts_n_in = 1'b1;
    expect_out(2, O_ALLOW, 1, "R2"); expect_out(3, O_ALLOW, 0, "R2");
    expect_out(3, O_HALT, 1, "R2");  expect_out(3, O_CSTAT, 1, "R10");
    expect_out(3, O_IRQ, 1, "R10");
    t(5);
    // R4 resume
    cts_n_in = 1'b0;
    expect_out(2, O_ALLOW, 0, "R4"); expect_out(3, O_ALLOW, 1, "R4");
    expect_out(3, O_HALT, 0, "R4");
    t(4);
    stat_rd = 1'b1; expect_out(1, O_CSTAT, 0, "R11"); t(1); stat_rd = 1'b0; t(1);
    // R3 stop request mid-character
    tx_busy = 1'b1; cts_n_in = 1'b1;
    expect_out(3, O_ALLOW, 0, "R3"); expect_out(3, O_HALT, 0, "R3");
    expect_out(5, O_HALT, 0, "R3");
    t(5);
    tx_stop_done = 1'b1; tx_busy = 1'b0;
    expect_out(1, O_HALT, 1, "R3"); expect_out(1, O_ALLOW, 0, "R3");
    t(1); tx_stop_done = 1'b0; t(1);
    cts_n_in = 1'b0; expect_out(3, O_ALLOW, 1, "R4"); t(4);
    stat_rd = 1'b1; t(1); stat_rd = 1'b0; t(1);
    // R5 automatic gating off
    auto_cts_en = 1'b0; cts_n_in = 1'b1;
    expect_out(3, O_ALLOW, 1, "R5"); expect_out(4, O_HALT, 0, "R5");
    expect_out(4, O_CSTAT, 0, "R5");
    t(5);
    cts_n_in = 1'b0; t(4); auto_cts_en = 1'b1; t(1);
    // R10 individual enable off
    cts_irq_en = 1'b0; cts_n_in = 1'b1;
    expect_out(3, O_ALLOW, 0, "R2"); expect_out(3, O_CSTAT, 0, "R10");
    t(5);
    cts_n_in = 1'b0; cts_irq_en = 1'b1; t(4);
    // R11 read lands on the set edge
    rx_level = LW'(9); expect_out(1, O_RSTAT, 1, "R10"); t(2);
    cts_n_in = 1'b1; t(2);
    stat_rd = 1'b1;
    expect_out(1, O_CSTAT, 1, "R11"); expect_out(1, O_RSTAT, 0, "R11");
    expect_out(1, O_IRQ, 1, "R11");
    t(1); stat_rd = 1'b0; t(1);
    stat_rd = 1'b1;
    expect_out(1, O_CSTAT, 0, "R11"); expect_out(1, O_IRQ, 0, "R11");
    t(1); stat_rd = 1'b0; t(3);
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: pending actual %0d expected 0", sb.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule